// File: doc/BRIEF.md
# Thread-Block Dispatcher

The dispatcher hands the blocks of one grid, one at a time, to a set of processing units. A grid is started with a single launch pulse that gives the number of blocks and the number of threads in every block. Blocks are issued in rising index order, starting at zero. Each block is sent whole to one unit, which is named by a one-hot assign strobe, and the block index is carried on a shared bus.

For every unit the dispatcher keeps a count of the blocks it holds and a count of the threads it holds. A unit can take a block only while it is under both limits: the block-slot limit and the thread limit. Whichever limit is reached first stops further blocks to that unit. Units can finish their blocks in any order. They signal each finished block with a one-cycle completion pulse, and that pulse gives back one slot and one block's worth of threads. The search for a unit with room goes round-robin and starts just after the unit that received the last block. When every block has been issued and every unit is empty, a done flag goes high. If the launch asks for a per-block thread count that no unit could ever hold, an error flag goes high and no block is issued.

Top module: `block_dispatcher`

## Requirements
- R1: After reset, all assign strobes are low, and grid_done and size_err are both low.
- R2: In any cycle, at most one bit of assign_vld is high.
- R3: The blocks of a grid are issued exactly once each, in the order 0, 1, 2, … up to the block count minus 1. assign_idx carries the index of the block being issued.
- R4: A unit never holds more than MAX_BLK (default 8) blocks. With 64-thread blocks and no completions, 16 units fill to exactly 128 blocks, and issue then stops.
- R5: A unit receives a block only if its resident thread count plus threads-per-block is at most MAX_THR (default 768). With 256-thread blocks, a unit holds at most 3 blocks. With 768-thread blocks, it holds 1.
- R6: The unit chosen is the first unit with room on both limits, scanning upward and wrapping from the unit after the last one that received a block. After reset the scan starts at unit 0.
- R7: A completion pulse on unit k in cycle t gives back one slot and threads-per-block to unit k. That capacity can be used from cycle t+1 onward.
- R8: grid_done is high once every block of the accepted grid has been issued and completed. It stays high until the next accepted launch. A grid of zero blocks is done at once.
- R9: A launch with threads-per-block equal to 0, or greater than MAX_THR, sets size_err. While size_err is high, nothing is issued.
- R10: If a unit receives a block and reports a completion in the same cycle, its block and thread counts are unchanged afterwards.
- R11: A launch pulse that arrives while a grid is still in progress is ignored. The running grid goes on with its own block count and threads-per-block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| launch | input | 1 | One-cycle pulse that starts a grid |
| launch_blocks | input | BLK_W | Number of blocks in the grid |
| launch_threads | input | TPB_W | Threads in each block |
| unit_done | input | NUM_UNITS | Per-unit completion pulse, one block per pulse |
| assign_vld | output | NUM_UNITS | One-hot strobe that names the unit receiving a block |
| assign_idx | output | BLK_W | Index of the block being issued |
| grid_done | output | 1 | Every block of the grid has been issued and completed |
| size_err | output | 1 | The launched threads-per-block can never fit in a unit |

## Verification
Issue and completion can land on the same unit in the same cycle. Completions are drawn at random for every occupied unit in every cycle, so this often happens while a unit is receiving a block. In the full-slot case it is also forced directly: all units are full, unit 3 is released, and its completion pulse is repeated in the cycle its refill is issued. The bench keeps its own per-unit slot and thread counts and applies both events at once. It then judges the outcome through the later round-robin choices. A unit whose counts drifted would be picked, or skipped, against the bench's expectation.

// File: rtl/disp_pkg.sv
package disp_pkg;
  // capacity test shared by the trackers: both limits must hold after adding a block
  function automatic logic unit_fits(input int unsigned slots, input int unsigned thr,
                                     input int unsigned tpb, input int unsigned max_blk,
                                     input int unsigned max_thr);
    return (slots < max_blk) && ((thr + tpb) <= max_thr);
  endfunction

  // a per-block size no unit could ever hold
  function automatic logic tpb_bad(input int unsigned tpb, input int unsigned max_thr);
    return (tpb == 0) || (tpb > max_thr);
  endfunction
endpackage

// File: rtl/disp_unit_slot.sv
module disp_unit_slot #(
  parameter int MAX_BLK = 8,
  parameter int MAX_THR = 768,
  parameter int SW      = 4,
  parameter int TW      = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic          free,
  input  logic [TW-1:0] tpb,
  output logic          room,
  output logic          occupied
);
  import disp_pkg::*;

  logic [SW-1:0] slots;
  logic [TW-1:0] thr;
  logic          free_ok;

  assign free_ok  = free && (slots != '0);
  assign room     = unit_fits(int'(slots), int'(thr), int'(tpb), MAX_BLK, MAX_THR);
  assign occupied = (slots != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slots <= '0;
      thr   <= '0;
    end else begin
      slots <= slots + SW'(take) - SW'(free_ok);
      thr   <= thr + (take ? tpb : '0) - (free_ok ? tpb : '0);
    end
  end

  AST_SLOT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    int'(slots) <= MAX_BLK); // R4
  AST_THR_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    int'(thr) <= MAX_THR); // R5
  AST_NET_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (take && free_ok) |=> (slots == $past(slots)) && (thr == $past(thr))); // R10
endmodule

// File: rtl/disp_rr_pick.sv
module disp_rr_pick #(
  parameter int N  = 16,
  parameter int IW = 4
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] last,
  output logic [N-1:0]  grant,
  output logic [IW-1:0] gidx
);
  function automatic logic [IW:0] first_after(input logic [N-1:0] r, input logic [IW-1:0] l);
    logic [IW:0] res;
    res = '0;
    for (int k = N; k >= 1; k--) begin
      int i;
      i = (int'(l) + k) % N;
      if (r[i]) res = {1'b1, IW'(i)};
    end
    return res;
  endfunction

  logic [IW:0] pick;
  assign pick = first_after(req, last);
  assign gidx = pick[IW-1:0];

  always_comb begin
    grant = '0;
    if (pick[IW]) grant[pick[IW-1:0]] = 1'b1;
  end
endmodule

// File: rtl/block_dispatcher.sv
module block_dispatcher #(
  parameter int NUM_UNITS = 16,
  parameter int MAX_BLK   = 8,
  parameter int MAX_THR   = 768,
  parameter int BLK_W     = 16,
  parameter int TPB_W     = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 launch,
  input  logic [BLK_W-1:0]     launch_blocks,
  input  logic [TPB_W-1:0]     launch_threads,
  input  logic [NUM_UNITS-1:0] unit_done,
  output logic [NUM_UNITS-1:0] assign_vld,
  output logic [BLK_W-1:0]     assign_idx,
  output logic                 grid_done,
  output logic                 size_err
);
  import disp_pkg::*;

  localparam int IW = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1;
  localparam int SW = $clog2(MAX_BLK + 1);

  logic             active;
  logic [BLK_W-1:0] total, next_idx;
  logic [TPB_W-1:0] tpb_r;
  logic [IW-1:0]    last;

  logic [NUM_UNITS-1:0] room, occ, req, grant;
  logic [IW-1:0]        gidx;
  logic                 want, empty, accept, issue;

  assign want   = active && (next_idx != total);
  assign empty  = (occ == '0);
  assign req    = want ? room : '0;
  assign issue  = (grant != '0);
  assign accept = launch && (!active || grid_done);

  assign assign_vld = grant;
  assign assign_idx = next_idx;
  assign grid_done  = active && !want && empty;

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    disp_unit_slot #(.MAX_BLK(MAX_BLK), .MAX_THR(MAX_THR), .SW(SW), .TW(TPB_W)) u_slot (
      .clk(clk), .rst_n(rst_n), .take(grant[u]), .free(unit_done[u]),
      .tpb(tpb_r), .room(room[u]), .occupied(occ[u]));
  end

  disp_rr_pick #(.N(NUM_UNITS), .IW(IW)) u_pick (
    .req(req), .last(last), .grant(grant), .gidx(gidx));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active   <= 1'b0;
      total    <= '0;
      next_idx <= '0;
      tpb_r    <= '0;
      size_err <= 1'b0;
      last     <= IW'(NUM_UNITS - 1);
    end else begin
      if (issue) begin
        next_idx <= next_idx + 1'b1;
        last     <= gidx;
      end
      if (accept) begin
        next_idx <= '0;
        total    <= launch_blocks;
        if (tpb_bad(int'(launch_threads), MAX_THR)) begin
          active   <= 1'b0;
          size_err <= 1'b1;
        end else begin
          active   <= 1'b1;
          size_err <= 1'b0;
          tpb_r    <= launch_threads;
        end
      end
    end
  end

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(assign_vld)); // R2
  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && !accept) |=> (assign_idx == $past(assign_idx) + 1'b1)); // R3
  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    size_err |-> (assign_vld == '0)); // R9
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    grid_done |-> (assign_vld == '0)); // R8
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && want) |=> (total == $past(total))); // R11
endmodule

// File: tb/sim_block_dispatcher.sv
module sim_block_dispatcher;
  localparam int NU = 16, MB = 8, MT = 768, BW = 16, TW = 10;

  logic clk = 0, rst_n = 0, launch = 0;
  logic [BW-1:0] launch_blocks = '0;
  logic [TW-1:0] launch_threads = '0;
  logic [NU-1:0] unit_done = '0;
  logic [NU-1:0] assign_vld;
  logic [BW-1:0] assign_idx;
  logic grid_done, size_err;

  always #5 clk = ~clk;

  block_dispatcher #(.NUM_UNITS(NU), .MAX_BLK(MB), .MAX_THR(MT), .BLK_W(BW), .TPB_W(TW)) u0 (
    .clk(clk), .rst_n(rst_n), .launch(launch), .launch_blocks(launch_blocks),
    .launch_threads(launch_threads), .unit_done(unit_done), .assign_vld(assign_vld),
    .assign_idx(assign_idx), .grid_done(grid_done), .size_err(size_err));

  int total = 0, bad = 0;
  int m_slots[NU], m_thr[NU];
  int m_last = NU - 1, m_next = 0, m_total = 0, m_tpb = 0, issued_cnt = 0;
  bit m_active = 0, m_err = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit m_empty();
    for (int u = 0; u < NU; u++) if (m_slots[u] != 0) return 0;
    return 1;
  endfunction

  function automatic int exp_pick();
    if (!(m_active && m_next != m_total)) return -1;
    for (int k = 1; k <= NU; k++) begin
      int i = (m_last + k) % NU;
      if (m_slots[i] < MB && m_thr[i] + m_tpb <= MT) return i;
    end
    return -1;
  endfunction

  function automatic int onehot_idx(input logic [NU-1:0] v);
    for (int u = 0; u < NU; u++) if (v[u]) return u;
    return -1;
  endfunction

  // one cycle: check outputs, drive done/launch for the next edge, update the model
  task automatic step(input int done_pct, input logic [NU-1:0] force_done, input bit do_launch,
                      input int lb, input int lt);
    int ep, gp;
    logic [NU-1:0] d;
    bit exp_done, acc;
    @(negedge clk);
    ep = exp_pick();
    gp = onehot_idx(assign_vld);
    chk($countones(assign_vld) <= 1, "R2", $countones(assign_vld), 1);
    chk(gp == ep, "R6/R4/R5", gp, ep);
    if (gp >= 0) chk(assign_idx == m_next, "R3", assign_idx, m_next);
    exp_done = m_active && m_next == m_total && m_empty();
    chk(grid_done == exp_done, "R8", grid_done, exp_done);
    chk(size_err == m_err, "R9", size_err, m_err);
    d = force_done;
    for (int u = 0; u < NU; u++)
      if (m_slots[u] > 0 && $urandom_range(99) < done_pct) d[u] = 1'b1;
    for (int u = 0; u < NU; u++) if (m_slots[u] == 0) d[u] = 1'b0;
    unit_done = d;
    launch = do_launch; launch_blocks = BW'(lb); launch_threads = TW'(lt);
    acc = do_launch && (!m_active || exp_done);
    if (ep >= 0) begin
      m_slots[ep]++; m_thr[ep] += m_tpb; m_next++; m_last = ep; issued_cnt++;
    end
    for (int u = 0; u < NU; u++)
      if (d[u]) begin m_slots[u]--; m_thr[u] -= (ep >= 0 && 0) ? 0 : m_tpb; end
    if (acc) begin
      m_next = 0; m_total = lb;
      if (lt == 0 || lt > MT) begin m_active = 0; m_err = 1; end
      else begin m_active = 1; m_err = 0; m_tpb = lt; end
    end
  endtask

  task automatic run(input int n, input int pct);
    for (int i = 0; i < n; i++) step(pct, '0, 0, 0, 0);
  endtask

  task automatic start(input int lb, input int lt);
    step(0, '0, 1, lb, lt);
    issued_cnt = 0;
  endtask

  task automatic drain();
    for (int i = 0; i < 3000 && !(grid_done && m_active); i++) step(30, '0, 0, 0, 0);
    chk(grid_done == 1, "R8 drain", grid_done, 1);
  endtask

  initial begin
    for (int u = 0; u < NU; u++) begin m_slots[u] = 0; m_thr[u] = 0; end
    void'($urandom(1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(assign_vld == '0, "R1 vld", assign_vld, 0);
    chk(grid_done == 0, "R1 done", grid_done, 0);
    chk(size_err == 0, "R1 err", size_err, 0);
    rst_n = 1;

    // 256-thread blocks: thread limit gives 3 per unit (R5), random completions (R7, R10)
    start(40, 256); run(60, 0); drain();
    chk(issued_cnt == 40, "R3 count", issued_cnt, 40);

    // 64-thread blocks: slot limit caps at 128 resident (R4)
    start(200, 64); run(160, 0);
    chk(issued_cnt == 128, "R4 fill", issued_cnt, 128);
    // launch while busy must be ignored (R11)
    step(0, '0, 1, 5, 100);
    chk(m_total == 200, "R11", m_total, 200);
    // release unit 3 only, then complete on 3 in the cycle it is refilled (R10, R7)
    step(0, 16'h0008, 0, 0, 0);
    step(0, 16'h0008, 0, 0, 0);
    run(4, 0);
    chk(issued_cnt == 130, "R10 R7 refill", issued_cnt, 130);
    drain();

    // boundary: exactly the thread limit per block, one per unit (R5)
    start(20, 768); run(20, 0);
    chk(issued_cnt == 16, "R5 full-limit", issued_cnt, 16);
    drain();

    // oversize and zero thread counts (R9)
    start(10, 800); run(20, 0);
    chk(issued_cnt == 0, "R9 oversize", issued_cnt, 0);
    start(10, 0); run(5, 0);
    chk(issued_cnt == 0, "R9 zero", issued_cnt, 0);

    // zero-block grid is done at once (R8)
    start(0, 32); run(2, 0);
    chk(grid_done == 1, "R8 empty grid", grid_done, 1);

    // random grids
    for (int g = 0; g < 6; g++) begin
      start(int'($urandom_range(300, 1)), int'($urandom_range(768, 1)));
      for (int i = 0; i < 400; i++) step(int'($urandom_range(40, 5)), '0, 0, 0, 0);
      drain();
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1500000;
    total++; bad++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule